// File: doc/BRIEF.md
# Cartridge Disk Controller Register File

This block is the bus-facing register set of a controller for up to four cartridge disk drives. Software sees five 16-bit word registers: control/status, bus address, disk address, a multipurpose register, and a bus address extension. The block decodes the word offset and merges byte writes into the current contents. It owns the interrupt request, and a control write with the done bit clear turns into a one-cycle start pulse. That pulse carries the function code and the selected drive to the seek and transfer logic.

The transfer and seek logic reports back through a completion pulse. The pulse carries error flags to be ORed into the status. It can also carry three words to preload the multipurpose queue, for example a status word or a header. The drive mechanics and memory traffic live entirely outside this block. A narrow-address mode input models a bus without the extension register.

Top module: `dkc_regs`

## Requirements
- R1: The register is chosen by busAddr[3:1]: 0 control/status, 1 bus address, 2 disk address, 3 multipurpose, 4 extension. Offsets 5 to 7 read as zero and writes to them change nothing.
- R2: Control/status reads as follows:
  - bit 0: drive ready, the inverse of driveBusy for the drive in bits 9:8.
  - bits 3:1: function.
  - bits 5:4: extension bits 1:0.
  - bit 6: interrupt enable.
  - bit 7: done.
  - bits 9:8: drive select.
  - bits 14:10: error flags, from bit 14 down: drive error, non-existent memory, header error, CRC error, incomplete.
  - bit 15: error summary.

  Only bits 9:1 are written by software.
- R3: Bit 15 reads as 1 whenever any of the error bits 14:10 is set.
- R4: Byte writes (busByte=1) carry their data on busWdata[7:0]. Odd address (busAddr[0]=1) replaces bits 15:8 and even address replaces bits 7:0; the other byte is kept.
- R5: A control write whose merged bit 7 is 1 starts nothing. If its bit 6 is 0 it withdraws irq; otherwise irq keeps its value.
- R6: A control write whose merged bit 7 is 0 does four things on the same edge: it clears irq, clears error bits 15:10, clears done, and registers a one-cycle cmdStart. cmdFunc carries bits 3:1 and cmdDrive carries bits 9:8.
- R7: Bit 0 of the bus address register always reads 0.
- R8: The extension register is 6 bits wide and ignores odd-byte writes. Its bits 1:0 and control bits 5:4 are one value, so a write through either register shows in both.
- R9: A multipurpose write loads all three queue slots with the merged value. A read returns slot 0, then slot 1 moves to slot 0 and slot 2 moves to slot 1, while slot 2 keeps its value.
- R10: With narrowMode=1, any access at offset 4 raises busErr in the same cycle, reads as zero and writes nothing.
- R11: After reset the control/status register holds only done, with bit 0 reflecting drive 0. All other registers and queue slots are zero, and irq and cmdStart are low.
- R12: A doneValid cycle sets done and ORs doneErr into bits 15:10. It sets irq to the current interrupt enable, and with doneMpWe=1 it loads slot i from doneMpData[16i+15:16i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| narrowMode | input | 1 | Bus without extension register |
| busSel | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 write, 0 read |
| busByte | input | 1 | Byte access |
| busAddr | input | 4 | Byte address within the block |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational |
| busErr | output | 1 | Access to an absent register |
| driveBusy | input | 4 | Per-drive busy from the drive logic |
| doneValid | input | 1 | Command completion pulse |
| doneErr | input | 6 | Error flags for control bits 15:10 |
| doneMpWe | input | 1 | Preload the multipurpose queue |
| doneMpData | input | 48 | Three queue words, slot 0 lowest |
| cmdStart | output | 1 | One-cycle command start |
| cmdFunc | output | 3 | Function code of the command |
| cmdDrive | output | 2 | Target drive of the command |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle:
- A control read with any error flag also shows the summary bit.
- A bus address read is always even.
- A start pulse only follows a control write, and irq is low whenever a start pulse is high.
- irq only rises after a completion.
- busErr appears only for an offset-4 access in narrow mode.

Only the bench scenarios can show the rest, because each needs a history of accesses: the order in which the multipurpose queue drains, byte-lane merging, the two-way extension mirror, and the way a done-set control write keeps or withdraws a pending interrupt.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  parameter int WORD_W     = 16;
  parameter int EXT_W      = 6;
  parameter int NUM_DRIVES = 4;
  localparam int HALF_W    = WORD_W / 2;
  localparam int DRV_W     = $clog2(NUM_DRIVES);
  localparam int FUNC_W    = 3;
  localparam int ERR_W     = 6;

  typedef enum logic [2:0] {
    SEL_CSR  = 3'd0,
    SEL_BA   = 3'd1,
    SEL_DA   = 3'd2,
    SEL_MP   = 3'd3,
    SEL_EXT  = 3'd4,
    SEL_NONE = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrCsr;
    logic    wrBa;
    logic    wrDa;
    logic    wrMp;
    logic    wrExt;
    logic    rdMp;
    logic    byteEn;
    logic    hiByte;
    regSel_e sel;
  } strobe_t;
endpackage

// File: rtl/dkc_regs_ctrl.sv
module dkc_regs_ctrl
  import dkc_pkg::*;
(
  input  logic       busSel,
  input  logic       busWrite,
  input  logic       busByte,
  input  logic [3:0] busAddr,
  input  logic       narrowMode,
  output strobe_t    strobe,
  output logic       busErr
);
  regSel_e sel;

  always_comb begin
    case (busAddr[3:1])
      3'd0:    sel = SEL_CSR;
      3'd1:    sel = SEL_BA;
      3'd2:    sel = SEL_DA;
      3'd3:    sel = SEL_MP;
      3'd4:    sel = narrowMode ? SEL_NONE : SEL_EXT;
      default: sel = SEL_NONE;
    endcase
  end

  assign busErr = busSel && narrowMode && (busAddr[3:1] == 3'd4);

  always_comb begin
    strobe        = '0;
    strobe.sel    = sel;
    strobe.byteEn = busByte;
    strobe.hiByte = busAddr[0];
    if (busSel) begin
      strobe.wrCsr = busWrite && (sel == SEL_CSR);
      strobe.wrBa  = busWrite && (sel == SEL_BA);
      strobe.wrDa  = busWrite && (sel == SEL_DA);
      strobe.wrMp  = busWrite && (sel == SEL_MP);
      strobe.wrExt = busWrite && (sel == SEL_EXT) && !(busByte && busAddr[0]);
      strobe.rdMp  = !busWrite && (sel == SEL_MP);
    end
  end
endmodule

// File: rtl/dkc_regs_dp.sv
module dkc_regs_dp
  import dkc_pkg::*;
#(
  parameter int MPQ_DEPTH = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strobe,
  input  logic [WORD_W-1:0]           busWdata,
  input  logic [NUM_DRIVES-1:0]       driveBusy,
  input  logic                        doneValid,
  input  logic [ERR_W-1:0]            doneErr,
  input  logic                        doneMpWe,
  input  logic [MPQ_DEPTH*WORD_W-1:0] doneMpData,
  output logic [WORD_W-1:0]           busRdata,
  output logic                        cmdStart,
  output logic [FUNC_W-1:0]           cmdFunc,
  output logic [DRV_W-1:0]            cmdDrive,
  output logic                        irq
);
  localparam logic [WORD_W-1:0] BA_MASK = ~WORD_W'(1);

  logic [FUNC_W-1:0] func;
  logic              intEn;
  logic              done;
  logic [DRV_W-1:0]  drive;
  logic [ERR_W-1:0]  errBits;
  logic [WORD_W-1:0] busAddrReg;
  logic [WORD_W-1:0] diskAddr;
  logic [EXT_W-1:0]  ext;
  logic [WORD_W-1:0] mpQ [MPQ_DEPTH];

  logic [WORD_W-1:0] csrView;
  logic [7:1]        csrLoNew;
  logic [DRV_W-1:0]  csrDrvNew;
  logic              loLaneWr;
  logic              hiLaneWr;
  logic [WORD_W-1:0] baNew;
  logic [WORD_W-1:0] daNew;
  logic [WORD_W-1:0] mpNew;

  function automatic logic [WORD_W-1:0] mergeWord(input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] wd,
                                                  input logic byteEn, input logic hi);
    if (!byteEn)  return wd;
    else if (hi)  return {wd[HALF_W-1:0], cur[HALF_W-1:0]};
    else          return {cur[WORD_W-1:HALF_W], wd[HALF_W-1:0]};
  endfunction

  assign csrView = {errBits[ERR_W-1] | (|errBits[ERR_W-2:0]), errBits[ERR_W-2:0],
                    drive, done, intEn, ext[1:0], func, ~driveBusy[drive]};

  assign loLaneWr  = !strobe.byteEn || !strobe.hiByte;
  assign hiLaneWr  = !strobe.byteEn || strobe.hiByte;
  assign csrLoNew  = loLaneWr ? busWdata[7:1] : csrView[7:1];
  assign csrDrvNew = !hiLaneWr ? drive :
                     (strobe.byteEn ? busWdata[DRV_W-1:0] : busWdata[HALF_W+DRV_W-1:HALF_W]);
  assign baNew = mergeWord(busAddrReg, busWdata, strobe.byteEn, strobe.hiByte);
  assign daNew = mergeWord(diskAddr, busWdata, strobe.byteEn, strobe.hiByte);
  assign mpNew = mergeWord(mpQ[0], busWdata, strobe.byteEn, strobe.hiByte);

  always_comb begin
    case (strobe.sel)
      SEL_CSR: busRdata = csrView;
      SEL_BA:  busRdata = busAddrReg;
      SEL_DA:  busRdata = diskAddr;
      SEL_MP:  busRdata = mpQ[0];
      SEL_EXT: busRdata = WORD_W'(ext);
      default: busRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      func       <= '0;
      intEn      <= 1'b0;
      done       <= 1'b1;
      drive      <= '0;
      errBits    <= '0;
      busAddrReg <= '0;
      diskAddr   <= '0;
      ext        <= '0;
      irq        <= 1'b0;
      cmdStart   <= 1'b0;
      cmdFunc    <= '0;
      cmdDrive   <= '0;
      for (int i = 0; i < MPQ_DEPTH; i++) mpQ[i] <= '0;
    end else begin
      cmdStart <= 1'b0;
      if (strobe.wrCsr) begin
        func     <= csrLoNew[3:1];
        ext[1:0] <= csrLoNew[5:4];
        intEn    <= csrLoNew[6];
        done     <= csrLoNew[7];
        drive    <= csrDrvNew;
        if (csrLoNew[7]) begin
          if (!csrLoNew[6]) irq <= 1'b0;
        end else begin
          irq      <= 1'b0;
          errBits  <= '0;
          cmdStart <= 1'b1;
          cmdFunc  <= csrLoNew[3:1];
          cmdDrive <= csrDrvNew;
        end
      end
      if (strobe.wrBa)  busAddrReg <= baNew & BA_MASK;
      if (strobe.wrDa)  diskAddr   <= daNew;
      if (strobe.wrExt) ext        <= busWdata[EXT_W-1:0];
      if (strobe.wrMp) begin
        for (int i = 0; i < MPQ_DEPTH; i++) mpQ[i] <= mpNew;
      end else if (strobe.rdMp) begin
        for (int i = 0; i < MPQ_DEPTH - 1; i++) mpQ[i] <= mpQ[i+1];
      end
      if (doneValid) begin
        done    <= 1'b1;
        errBits <= errBits | doneErr;
        irq     <= intEn;
        if (doneMpWe) begin
          for (int i = 0; i < MPQ_DEPTH; i++) mpQ[i] <= doneMpData[i*WORD_W +: WORD_W];
        end
      end
    end
  end
endmodule

// File: rtl/dkc_regs.sv
module dkc_regs
  import dkc_pkg::*;
#(
  parameter int MPQ_DEPTH = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        narrowMode,
  input  logic                        busSel,
  input  logic                        busWrite,
  input  logic                        busByte,
  input  logic [3:0]                  busAddr,
  input  logic [WORD_W-1:0]           busWdata,
  output logic [WORD_W-1:0]           busRdata,
  output logic                        busErr,
  input  logic [NUM_DRIVES-1:0]       driveBusy,
  input  logic                        doneValid,
  input  logic [ERR_W-1:0]            doneErr,
  input  logic                        doneMpWe,
  input  logic [MPQ_DEPTH*WORD_W-1:0] doneMpData,
  output logic                        cmdStart,
  output logic [FUNC_W-1:0]           cmdFunc,
  output logic [DRV_W-1:0]            cmdDrive,
  output logic                        irq
);
  strobe_t strobe;

  dkc_regs_ctrl u_ctrl (
    .busSel(busSel), .busWrite(busWrite), .busByte(busByte), .busAddr(busAddr),
    .narrowMode(narrowMode), .strobe(strobe), .busErr(busErr)
  );

  dkc_regs_dp #(.MPQ_DEPTH(MPQ_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .driveBusy(driveBusy), .doneValid(doneValid), .doneErr(doneErr),
    .doneMpWe(doneMpWe), .doneMpData(doneMpData), .busRdata(busRdata),
    .cmdStart(cmdStart), .cmdFunc(cmdFunc), .cmdDrive(cmdDrive), .irq(irq)
  );
endmodule

// File: rtl/dkc_regs_checker.sv
module dkc_regs_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWrite,
  input logic [2:0]  regOff,
  input logic [15:0] busRdata,
  input logic        busErr,
  input logic        narrowMode,
  input logic        cmdStart,
  input logic        irq,
  input logic        doneValid
);
  assert_err_summary_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && regOff == 3'd0 && |busRdata[14:10]) |-> busRdata[15]);

  assert_ba_even_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && regOff == 3'd1) |-> !busRdata[0]);

  assert_start_from_csr_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> $past(busSel && busWrite && regOff == 3'd0));

  assert_start_drops_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> !irq);

  assert_irq_after_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(doneValid));

  assert_buserr_narrow_R10: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (narrowMode && busSel && regOff == 3'd4));
endmodule

bind dkc_regs dkc_regs_checker u_dkc_regs_checker (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .regOff(busAddr[3:1]), .busRdata(busRdata), .busErr(busErr),
  .narrowMode(narrowMode), .cmdStart(cmdStart), .irq(irq), .doneValid(doneValid)
);

// File: tb/dkc_regs_bench.sv
`timescale 1ns/1ps
module dkc_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        narrowMode = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0, busByte = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        busErr;
  logic [3:0]  driveBusy = '0;
  logic        doneValid = 1'b0;
  logic [5:0]  doneErr = '0;
  logic        doneMpWe = 1'b0;
  logic [47:0] doneMpData = '0;
  logic        cmdStart;
  logic [2:0]  cmdFunc;
  logic [1:0]  cmdDrive;
  logic        irq;

  dkc_regs u_dkc_regs (
    .clk(clk), .rstN(rstN), .narrowMode(narrowMode), .busSel(busSel),
    .busWrite(busWrite), .busByte(busByte), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr), .driveBusy(driveBusy), .doneValid(doneValid),
    .doneErr(doneErr), .doneMpWe(doneMpWe), .doneMpData(doneMpData),
    .cmdStart(cmdStart), .cmdFunc(cmdFunc), .cmdDrive(cmdDrive), .irq(irq)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  logic [2:0]  mFunc = '0;
  logic        mIe = 1'b0, mDone = 1'b1, mIrq = 1'b0, mNarrow = 1'b0;
  logic [1:0]  mDrive = '0;
  logic [5:0]  mErr = '0, mExt = '0;
  logic [15:0] mBa = '0, mDa = '0;
  logic [15:0] mMp [3];

  function automatic logic [15:0] expCsr();
    return {mErr[5] | (|mErr[4:0]), mErr[4:0], mDrive, mDone, mIe, mExt[1:0], mFunc,
            ~driveBusy[mDrive]};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] cur, input logic [15:0] d,
                                        input bit isByte, input bit odd);
    if (!isByte) return d;
    return odd ? {d[7:0], cur[7:0]} : {cur[15:8], d[7:0]};
  endfunction

  function automatic string tagOf(input logic [2:0] off);
    case (off)
      3'd0: return "R2";
      3'd1: return "R7";
      3'd2: return "R1";
      3'd3: return "R9";
      3'd4: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [2:0] off, input bit isByte, input bit odd,
                       input logic [15:0] d, input string tag);
    logic [15:0] m;
    bit          expStart = 0;
    logic [2:0]  eF = '0;
    logic [1:0]  eD = '0;
    logic        expErr = (off == 3'd4) && mNarrow;
    case (off)
      3'd0: begin
        m = merge(expCsr(), d, isByte, odd);
        mFunc = m[3:1]; mExt[1:0] = m[5:4]; mIe = m[6]; mDone = m[7]; mDrive = m[9:8];
        if (m[7]) begin
          if (!m[6]) mIrq = 1'b0;
        end else begin
          mIrq = 1'b0; mErr = '0; expStart = 1; eF = m[3:1]; eD = m[9:8];
        end
      end
      3'd1: mBa = merge(mBa, d, isByte, odd) & 16'hFFFE;
      3'd2: mDa = merge(mDa, d, isByte, odd);
      3'd3: begin
        m = merge(mMp[0], d, isByte, odd);
        for (int i = 0; i < 3; i++) mMp[i] = m;
      end
      3'd4: if (!mNarrow && !(isByte && odd)) mExt = d[5:0];
      default: ;
    endcase
    busSel = 1; busWrite = 1; busByte = isByte; busAddr = {off, odd}; busWdata = d;
    #2 check({tag, " busErr"}, busErr, expErr);
    @(negedge clk);
    busSel = 0; busWrite = 0; busByte = 0;
    check({tag, " R6 start"}, cmdStart, expStart);
    if (expStart) check({tag, " R6 cmd"}, {cmdDrive, cmdFunc}, {eD, eF});
    check({tag, " irq"}, irq, mIrq);
  endtask

  task automatic busRd(input logic [2:0] off, input string tag);
    logic [15:0] e;
    case (off)
      3'd0: e = expCsr();
      3'd1: e = mBa;
      3'd2: e = mDa;
      3'd3: e = mMp[0];
      3'd4: e = mNarrow ? 16'h0 : {10'h0, mExt};
      default: e = 16'h0;
    endcase
    busSel = 1; busWrite = 0; busByte = 0; busAddr = {off, 1'b0};
    #2 check({tag, " rdata"}, busRdata, e);
    check({tag, " busErr"}, busErr, (off == 3'd4) && mNarrow);
    @(negedge clk);
    busSel = 0;
    if (off == 3'd3) begin
      mMp[0] = mMp[1]; mMp[1] = mMp[2];
    end
  endtask

  task automatic doneEvt(input logic [5:0] e, input bit ld, input logic [47:0] w);
    doneValid = 1; doneErr = e; doneMpWe = ld; doneMpData = w;
    @(negedge clk);
    doneValid = 0; doneMpWe = 0;
    mDone = 1; mErr = mErr | e; mIrq = mIe;
    if (ld) for (int i = 0; i < 3; i++) mMp[i] = w[i*16 +: 16];
    check("R12 irq", irq, mIrq);
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) mMp[i] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    check("R11 csr", expCsr(), 16'h0081);
    busRd(0, "R11"); busRd(1, "R11"); busRd(2, "R11"); busRd(4, "R11");
    check("R11 irq", irq, 1'b0);
    check("R11 start", cmdStart, 1'b0);

    busWr(0, 0, 0, 16'h020C, "R6 go");
    driveBusy = 4'b0100;
    busRd(0, "R2 ready follows busy");
    doneEvt(6'b000100, 0, '0);
    busRd(0, "R3 summary");
    driveBusy = 4'b0000;

    busWr(0, 0, 0, 16'h00C0, "R5 done set");
    busWr(0, 0, 0, 16'h0046, "R6 clear errors");
    busRd(0, "R6 errs gone");
    doneEvt(6'b000000, 1, {16'hCCCC, 16'hBBBB, 16'hAAAA});
    check("R12 irq raised", irq, 1'b1);
    busWr(0, 0, 0, 16'h00C0, "R5 keep irq");
    busWr(0, 0, 0, 16'h0080, "R5 drop irq");

    busRd(3, "R9 head"); busRd(3, "R9 second"); busRd(3, "R9 third"); busRd(3, "R9 tail stays");
    busWr(3, 0, 0, 16'h1234, "R9 load");
    busRd(3, "R9 all slots"); busRd(3, "R9 all slots");

    busWr(2, 0, 0, 16'hABCD, "R4 word");
    busWr(2, 1, 1, 16'h0055, "R4 odd byte");
    busRd(2, "R4 high replaced");
    busWr(2, 1, 0, 16'h0011, "R4 even byte");
    busRd(2, "R4 low replaced");
    busWr(1, 1, 0, 16'h00FF, "R7 byte");
    busRd(1, "R7 even");

    busWr(4, 0, 0, 16'hFFEA, "R8 ext");
    busRd(0, "R8 mirror out");
    busWr(4, 1, 1, 16'h0015, "R8 odd ignored");
    busRd(4, "R8 unchanged");
    busWr(0, 0, 0, 16'h0090, "R8 mirror in");
    busRd(4, "R8 mirror in");

    mNarrow = 1; narrowMode = 1;
    busWr(4, 0, 0, 16'h0003, "R10 write");
    busRd(4, "R10 read");
    mNarrow = 0; narrowMode = 0;
    busRd(4, "R10 no effect");

    busRd(5, "R1 unused");
    busWr(6, 0, 0, 16'hFFFF, "R1 unused write");
    busRd(2, "R1 da kept");
    busWr(0, 0, 0, 16'hFC81, "R2 read-only bits");
    busRd(0, "R2 read-only bits");

    for (int n = 0; n < 800; n++) begin
      int op = $urandom_range(0, 11);
      if (op <= 4) begin
        bit isByte = 1'($urandom_range(0, 1));
        bit odd = isByte ? 1'($urandom_range(0, 1)) : 1'b0;
        busWr(3'(op), isByte, odd, 16'($urandom), tagOf(3'(op)));
      end else if (op <= 7 || op == 11) begin
        logic [2:0] off = (op == 11) ? 3'd0 : 3'($urandom_range(0, 5));
        busRd(off, tagOf(off));
      end else if (op == 8) begin
        doneEvt(6'($urandom), 1'($urandom_range(0, 1)), {16'($urandom), 16'($urandom), 16'($urandom)});
      end else if (op == 9) begin
        mNarrow = ($urandom_range(0, 3) == 0); narrowMode = mNarrow;
      end else begin
        driveBusy = 4'($urandom);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule